// File: doc/BRIEF.md
# Independent Hardware Watchdog Timer

This block is a fixed-length watchdog that runs from the 32768 Hz crystal clock and stands apart from any watchdog inside the processor. Firmware keeps it quiet by writing a one to a refresh bit in its control register. If no refresh arrives within the timeout, it raises a system reset. That reset holds the processor for a fixed number of crystal cycles, and the processor then restarts from address zero. A sticky overflow flag tells boot code whether the last restart came from the watchdog or from a power-up.

No register bit can stop the count. Only three things stop it: a debug strap input, an emulator-enable input, or the wake signal. The debug strap is ignored while the brownout indication is high, so in that mode the emulator-enable input is the only disable that still works. The external reset pin is an asynchronous, active-high input. It clears every state of the block, the sticky flag included.

Top module: `hw_watchdog`

## Requirements
- R1: After a restart, with the count enabled and no refresh, `wdt_rst` rises at the clock edge that ends the TIMEOUT_CYC-th enabled cycle (49152 cycles by default, 1.5 s of crystal time), and not before.
- R2: A write to address 0 with data bit 0 set restarts the count from zero, so the next overflow is a full TIMEOUT_CYC enabled cycles later.
- R3: A refresh write in the same cycle as terminal count wins: no overflow happens and the count restarts.
- R4: While `wake` is low, the count is held at its restarted value and no overflow can occur.
- R5: After an overflow, `wdt_rst` stays high for exactly HOLD_CYC cycles (4100 by default) and then falls. The count then starts again from zero.
- R6: The overflow flag sets on overflow and reads back as bit 1 of address 0 on `reg_rdata` and on `ovf_flag`. It stays set until it is cleared.
- R7: A write to address 0 with data bit 1 set clears the flag, and `ext_rst` clears it too. If an overflow and a clear fall in the same cycle, the overflow wins.
- R8: Register writes are ignored while `wdt_rst` is high. The flag keeps its value through the whole hold.
- R9: A high `emu_en` holds the count restarted, whatever the level of `brownout`.
- R10: A high `dbg_strap` holds the count restarted only while `brownout` is low. While `brownout` is high, the strap has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32768 Hz crystal clock |
| ext_rst | input | 1 | External reset pin, async, active high |
| wake | input | 1 | Wake signal; low holds the count restarted |
| dbg_strap | input | 1 | Debug strap disable |
| emu_en | input | 1 | Emulator-enable disable |
| brownout | input | 1 | Brownout mode indication |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address; control lives at 0 |
| reg_wdata | input | DATA_W | Write data: bit 0 refresh, bit 1 clear flag |
| reg_rdata | output | DATA_W | Read data: bit 1 overflow flag |
| wdt_rst | output | 1 | Watchdog system reset, active high |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
Two functions can fall in the same cycle. A refresh write can land on the terminal-count cycle, and a flag-clear write can land on the overflow cycle itself. The bench provokes both on purpose by counting enabled cycles from a known restart. It then judges them by whether `wdt_rst` rises one edge later and by what the flag reads afterwards. Random traffic also sets these events against the disable inputs and `wake`. A bench model, built from the requirements alone, compares the outputs every cycle.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int CTRL_ADDR   = 0;
  localparam int REFRESH_BIT = 0;
  localparam int OVF_BIT     = 1;

  // width large enough to hold values 0..n-1 (at least one bit)
  function automatic int cnt_width(input int n);
    return (n > 2) ? $clog2(n) : 1;
  endfunction

  // count is enabled when wake is high and no disable applies
  function automatic logic run_enable(input logic wake, input logic emu,
                                      input logic strap, input logic brown);
    return wake & ~emu & ~(strap & ~brown);
  endfunction
endpackage

// File: rtl/wdt_timebase.sv
module wdt_timebase #(
  parameter int TIMEOUT_CYC = 49152
) (
  input  logic clk,
  input  logic ext_rst,
  input  logic run_en,
  input  logic refresh,
  input  logic hold,
  output logic ovf_evt
);
  localparam int CW = wdt_pkg::cnt_width(TIMEOUT_CYC);
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYC - 1);

  logic [CW-1:0] cnt;
  logic          at_last;

  assign at_last = (cnt == LAST);
  assign ovf_evt = run_en & ~refresh & ~hold & at_last;

  always_ff @(posedge clk or posedge ext_rst) begin
    if (ext_rst)                              cnt <= '0;
    else if (hold || !run_en || refresh || at_last) cnt <= '0;
    else                                      cnt <= cnt + 1'b1;
  end

  AST_HALT_RESTARTS: assert property (@(posedge clk) disable iff (ext_rst)
    !run_en |=> (cnt == '0)); // R4
  AST_REFRESH_WINS: assert property (@(posedge clk) disable iff (ext_rst)
    (refresh && at_last) |-> !ovf_evt); // R3
endmodule

// File: rtl/wdt_hold.sv
module wdt_hold #(
  parameter int HOLD_CYC = 4100
) (
  input  logic clk,
  input  logic ext_rst,
  input  logic ovf_evt,
  output logic wdt_rst
);
  localparam int HW = wdt_pkg::cnt_width(HOLD_CYC);

  logic [HW-1:0] left;
  logic          last_hold;

  assign last_hold = (left == '0);

  always_ff @(posedge clk or posedge ext_rst) begin
    if (ext_rst) begin
      wdt_rst <= 1'b0;
      left    <= '0;
    end else if (wdt_rst) begin
      if (last_hold) wdt_rst <= 1'b0;
      else           left    <= left - 1'b1;
    end else if (ovf_evt) begin
      wdt_rst <= 1'b1;
      left    <= HW'(HOLD_CYC - 1);
    end
  end

  AST_OVF_RAISES_RST: assert property (@(posedge clk) disable iff (ext_rst)
    (ovf_evt && !wdt_rst) |=> wdt_rst); // R5
endmodule

// File: rtl/wdt_status.sv
module wdt_status (
  input  logic clk,
  input  logic ext_rst,
  input  logic set_evt,
  input  logic clr_req,
  output logic flag
);
  always_ff @(posedge clk or posedge ext_rst) begin
    if (ext_rst)      flag <= 1'b0;
    else if (set_evt) flag <= 1'b1;
    else if (clr_req) flag <= 1'b0;
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (ext_rst)
    set_evt |=> flag); // R7
endmodule

// File: rtl/hw_watchdog.sv
module hw_watchdog #(
  parameter int TIMEOUT_CYC = 49152,
  parameter int HOLD_CYC    = 4100,
  parameter int ADDR_W      = 2,
  parameter int DATA_W      = 8
) (
  input  logic              clk,
  input  logic              ext_rst,
  input  logic              wake,
  input  logic              dbg_strap,
  input  logic              emu_en,
  input  logic              brownout,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              wdt_rst,
  output logic              ovf_flag
);
  import wdt_pkg::*;

  logic ctrl_sel, wr_ok, refresh, clr_req, run_en, ovf_evt;
  logic unused_wdata;

  assign ctrl_sel = (reg_addr == ADDR_W'(CTRL_ADDR));
  assign wr_ok    = reg_wr & ctrl_sel & ~wdt_rst;
  assign refresh  = wr_ok & reg_wdata[REFRESH_BIT];
  assign clr_req  = wr_ok & reg_wdata[OVF_BIT];
  assign run_en   = run_enable(wake, emu_en, dbg_strap, brownout);
  assign unused_wdata = &{1'b0, reg_wdata};

  wdt_timebase #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_tb (
    .clk(clk), .ext_rst(ext_rst), .run_en(run_en), .refresh(refresh),
    .hold(wdt_rst), .ovf_evt(ovf_evt));

  wdt_hold #(.HOLD_CYC(HOLD_CYC)) u_hold (
    .clk(clk), .ext_rst(ext_rst), .ovf_evt(ovf_evt), .wdt_rst(wdt_rst));

  wdt_status u_stat (
    .clk(clk), .ext_rst(ext_rst), .set_evt(ovf_evt), .clr_req(clr_req),
    .flag(ovf_flag));

  always_comb begin
    reg_rdata = '0;
    if (ctrl_sel) reg_rdata[OVF_BIT] = ovf_flag;
  end

  AST_FLAG_WITH_RST: assert property (@(posedge clk) disable iff (ext_rst)
    $rose(wdt_rst) |-> ovf_flag); // R6
  AST_FLAG_KEPT_IN_HOLD: assert property (@(posedge clk) disable iff (ext_rst)
    (wdt_rst && $past(wdt_rst)) |-> $stable(ovf_flag)); // R8
  AST_EMU_STOPS: assert property (@(posedge clk) disable iff (ext_rst)
    (emu_en && !wdt_rst) |=> !wdt_rst); // R9
endmodule

// File: tb/sim_hw_watchdog.sv
module sim_hw_watchdog;
  localparam int T = 40;
  localparam int H = 9;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic ext_rst = 1'b1, wake = 1'b1, dbg_strap = 1'b0, emu_en = 1'b0, brownout = 1'b0;
  logic reg_wr = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic wdt_rst, ovf_flag;

  int n_run = 0, n_fail = 0;
  int m_cnt = 0, m_hold = 0;
  bit m_rst = 0, m_flag = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hw_watchdog #(.TIMEOUT_CYC(T), .HOLD_CYC(H), .ADDR_W(2), .DATA_W(8)) u0 (
    .clk(clk), .ext_rst(ext_rst), .wake(wake), .dbg_strap(dbg_strap),
    .emu_en(emu_en), .brownout(brownout), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .wdt_rst(wdt_rst), .ovf_flag(ovf_flag));

  function automatic bit exp_enable(bit wk, bit emu, bit strap, bit brown);
    if (!wk || emu) return 0;
    if (strap && !brown) return 0;
    return 1;
  endfunction

  function automatic logic [7:0] exp_rdata(logic [1:0] a, bit flag);
    return (a == 2'd0) ? {6'd0, flag, 1'b0} : 8'd0;
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // one clock: model advances with the inputs held, outputs compared at negedge
  task automatic step(string tag);
    bit wr_ok, refr, clr, en;
    @(posedge clk);
    if (ext_rst) begin
      m_cnt = 0; m_hold = 0; m_rst = 0; m_flag = 0;
    end else begin
      wr_ok = reg_wr && reg_addr == 2'd0 && !m_rst;
      refr  = wr_ok && reg_wdata[0];
      clr   = wr_ok && reg_wdata[1];
      en    = exp_enable(wake, emu_en, dbg_strap, brownout);
      if (m_rst) begin
        m_cnt = 0;
        if (m_hold == 0) m_rst = 0; else m_hold--;
        if (clr) m_flag = 0;
      end else if (!en || refr) begin
        m_cnt = 0;
        if (clr) m_flag = 0;
      end else if (m_cnt == T-1) begin
        m_cnt = 0; m_rst = 1; m_hold = H-1; m_flag = 1;
      end else begin
        m_cnt++;
        if (clr) m_flag = 0;
      end
    end
    @(negedge clk);
    check(tag, "wdt_rst", wdt_rst, m_rst);
    check(tag, "ovf_flag", ovf_flag, m_flag);
    check(tag, "rdata", reg_rdata, exp_rdata(reg_addr, m_flag));
  endtask

  task automatic idle(string tag, int n);
    for (int i = 0; i < n; i++) step(tag);
  endtask

  task automatic wr(string tag, logic [7:0] d);
    reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = d;
    step(tag);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog timeout actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : stim
    int hi;
    void'($urandom(32'd1234));
    @(negedge clk);
    step("R6");
    check("R6", "reset wdt_rst", wdt_rst, 0);
    check("R6", "reset ovf_flag", ovf_flag, 0);
    ext_rst = 1'b0;
    // R1: exact timeout edge
    idle("R1", T-1);
    check("R1", "no early reset", wdt_rst, 0);
    step("R1");
    check("R1", "reset at timeout", wdt_rst, 1);
    check("R6", "flag set on overflow", ovf_flag, 1);
    // R8: writes during hold ignored
    wr("R8", 8'h03);
    check("R8", "flag kept in hold", ovf_flag, 1);
    // R5: hold length
    hi = 2;
    while (wdt_rst && hi < 3*H) begin step("R5"); if (wdt_rst) hi++; end
    check("R5", "hold cycles", hi, H);
    // R7: clear
    wr("R7", 8'h02);
    check("R7", "w1c clears", ovf_flag, 0);
    // R2: refresh midway restarts
    idle("R2", T/2);
    wr("R2", 8'h01);
    idle("R2", T-1);
    check("R2", "restart delays reset", wdt_rst, 0);
    step("R2");
    check("R2", "reset after full count", wdt_rst, 1);
    idle("R5", H);
    // R3: refresh on terminal cycle; R7 clear on overflow cycle loses
    idle("R3", T-1);
    wr("R3", 8'h01);
    check("R3", "terminal refresh wins", wdt_rst, 0);
    idle("R7", T-1);
    wr("R7", 8'h02);
    check("R7", "set beats clear", ovf_flag, 1);
    idle("R5", H);
    // R4: wake low holds count
    wake = 1'b0; idle("R4", 2*T); check("R4", "wake low no reset", wdt_rst, 0);
    wake = 1'b1;
    // R9: emu_en with brownout
    emu_en = 1'b1; brownout = 1'b1; idle("R9", 2*T);
    check("R9", "emu disables", wdt_rst, 0);
    emu_en = 1'b0; brownout = 1'b0;
    // R10: strap only without brownout
    dbg_strap = 1'b1; idle("R10", 2*T);
    check("R10", "strap disables", wdt_rst, 0);
    brownout = 1'b1; idle("R10", T);
    check("R10", "strap ignored in brownout", wdt_rst, 1);
    dbg_strap = 1'b0; brownout = 1'b0;
    idle("R5", H);
    // R7: ext_rst clears flag
    ext_rst = 1'b1; step("R7"); check("R7", "pin clears flag", ovf_flag, 0);
    ext_rst = 1'b0;
    // random traffic
    for (int i = 0; i < 6000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      wake      = ($urandom_range(0, 19) != 0);
      emu_en    = ($urandom_range(0, 29) == 0);
      dbg_strap = ($urandom_range(0, 24) == 0);
      brownout  = ($urandom_range(0, 3) == 0);
      reg_wr    = (r < 4);
      reg_addr  = 2'($urandom_range(0, 3));
      reg_wdata = 8'($urandom_range(0, 255));
      ext_rst   = (r == 99);
      step("R1");
    end
    reg_wr = 1'b0; ext_rst = 1'b0;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule